// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor-facing programming port of a four-channel DMA controller. Software selects one of sixteen register locations with a 4-bit address, moves one byte per access over an 8-bit data bus, and qualifies each access with a select plus read and write strobes. Behind the port sit the per-channel start address, transfer count and mode, plus the shared command, software request, channel mask and status registers. The outputs feed the transfer sequencer, which lives outside this block. Terminal-count events come in from that sequencer as pulses.

Each 16-bit register is reached one byte at a time. A single byte-pointer state machine chooses which byte is reached. It has two states. `PTR_LO` selects bits 7:0 and `PTR_HI` selects bits 15:8. The `PTR_LO -> PTR_HI` transition and the `PTR_HI -> PTR_LO` transition happen on every access to a channel address or count location. A pointer-clear write or a master clear forces the state back to `PTR_LO` from either state. Several locations mean one thing on a read and another on a write.

Top module: `dmac_regif`

## Requirements
- R1: After reset all four mask bits are 1. The command, software request and terminal-count flags are 0, and the byte pointer is in `PTR_LO`.
- R2: A write to location 2*n reaches the address register of channel n, and a write to 2*n+1 reaches its count register (n = 0..3). The write loads the same byte of both the base copy and the current copy: bits 7:0 in `PTR_LO`, bits 15:8 in `PTR_HI`.
- R3: Every read or write of locations 0..7 toggles the byte pointer. A write to location 12 returns it to `PTR_LO`.
- R4: A read of locations 0..7 returns the byte of the current copy that the pointer selects.
- R5: A write to location 8 loads the 8-bit command register, and a read of location 10 returns it. A read of location 8 returns status, with the live request inputs in bits 7:4 and the terminal-count flags in bits 3:0 (bit n = channel n).
- R6: A terminal-count pulse on channel n sets flag n, and the flag holds until a status read clears it. A pulse that arrives in the same cycle as the status read leaves its flag set afterwards.
- R7: A write to location 9 changes one software request bit. Data bits 1:0 pick the channel, and bit 2 sets the bit (1) or clears it (0).
- R8: A write to location 10 changes one mask bit with the same encoding: bits 1:0 pick the channel, and bit 2 sets (1) or clears (0). A mask bit of 1 disables that channel.
- R9: A write to location 15 loads all four mask bits from data bits 3:0. A write to location 14 clears all four.
- R10: A write to location 11 stores data bits 7:2 as the 6-bit mode of the channel chosen by data bits 1:0.
- R11: A write to location 13 (master clear) zeroes the command, software request and terminal-count flags, sets all four mask bits and returns the pointer to `PTR_LO`. Channel registers and modes keep their values.
- R12: Nothing happens unless select is high. If read and write are both high, only the write acts. Reads of locations that have no read meaning return 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational; 0 when not reading) |
| dreq_in | input | 4 | Live channel request lines |
| tc_evt | input | 4 | Terminal-count pulses from the sequencer |
| command_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| sw_req_o | output | 4 | Software request bits |
| base_addr_o | output | 64 | Base address, channel n at [16n+:16] |
| cur_addr_o | output | 64 | Current address, channel n at [16n+:16] |
| base_cnt_o | output | 64 | Base count, channel n at [16n+:16] |
| cur_cnt_o | output | 64 | Current count, channel n at [16n+:16] |
| mode_o | output | 24 | Channel modes, channel n at [6n+:6] |

## Verification
Two events can land in the same cycle: a status read that clears the terminal-count flags and a fresh terminal-count pulse from the sequencer. The bench raises a pulse on the same edge as a status read. It expects the read data to show the old flags, the next status read to show the new flag, and a third read to show it cleared. It also applies read and write together on location 8 while a flag is pending. The command must change and the flag must survive, which shows that the read-side clear did not act.

// File: rtl/dmac_regif_pkg.sv
package dmac_regif_pkg;

    localparam int NUM_CH   = 4;
    localparam int CH_SEL_W = $clog2(NUM_CH);
    localparam int REG_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int MODE_W   = 6;

    localparam logic [3:0] LOC_STAT_CMD  = 4'd8;
    localparam logic [3:0] LOC_REQ       = 4'd9;
    localparam logic [3:0] LOC_MASK_ONE  = 4'd10;
    localparam logic [3:0] LOC_MODE      = 4'd11;
    localparam logic [3:0] LOC_PTR_CLR   = 4'd12;
    localparam logic [3:0] LOC_MCLR      = 4'd13;
    localparam logic [3:0] LOC_MASK_NONE = 4'd14;
    localparam logic [3:0] LOC_MASK_ALL  = 4'd15;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_e;

endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr
    import dmac_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clear,
    output logic hi_sel
);

    ptr_state_e state_q;
    ptr_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = PTR_LO;
        end else if (access) begin
            unique case (state_q)
                PTR_LO: state_d = PTR_HI;
                PTR_HI: state_d = PTR_LO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        hi_sel = (state_q == PTR_HI);
    end

    // R3
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clear) |=> (hi_sel != $past(hi_sel)));

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hi_sel);

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_regif_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int MW = MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  logic [MW-1:0]     mode_in,
    output logic [RW-1:0]     base_addr,
    output logic [RW-1:0]     cur_addr,
    output logic [RW-1:0]     base_cnt,
    output logic [RW-1:0]     cur_cnt,
    output logic [MW-1:0]     mode
);

    localparam int LANE = BYTE_W;

    logic [RW-1:0] base_addr_q, cur_addr_q, base_cnt_q, cur_cnt_q;
    logic [MW-1:0] mode_q;
    int            lane_lsb;

    always_comb lane_lsb = int'(hi_sel) * LANE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            cur_addr_q  <= '0;
            base_cnt_q  <= '0;
            cur_cnt_q   <= '0;
            mode_q      <= '0;
        end else begin
            if (addr_we) begin
                base_addr_q[lane_lsb +: LANE] <= wdata;
                cur_addr_q[lane_lsb +: LANE]  <= wdata;
            end
            if (cnt_we) begin
                base_cnt_q[lane_lsb +: LANE] <= wdata;
                cur_cnt_q[lane_lsb +: LANE]  <= wdata;
            end
            if (mode_we) mode_q <= mode_in;
        end
    end

    assign base_addr = base_addr_q;
    assign cur_addr  = cur_addr_q;
    assign base_cnt  = base_cnt_q;
    assign cur_cnt   = cur_cnt_q;
    assign mode      = mode_q;

    // R2
    addr_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && !hi_sel) |=> (cur_addr[7:0] == $past(wdata) && base_addr[7:0] == $past(wdata)));

    // R2
    cnt_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && hi_sel) |=> (cur_cnt[15:8] == $past(wdata) && base_cnt[15:8] == $past(wdata)));

endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              req_we,
    input  logic              mask_one_we,
    input  logic              mask_all_we,
    input  logic              mask_none_we,
    input  logic              mclr,
    input  logic              stat_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NUM_CH-1:0] tc_evt,
    output logic [BYTE_W-1:0] command,
    output logic [NUM_CH-1:0] sw_req,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] tc_flags
);

    logic [BYTE_W-1:0]   cmd_q;
    logic [NUM_CH-1:0]   req_q, mask_q, tc_q;
    logic [CH_SEL_W-1:0] ch_pick;
    logic                set_bit;
    logic [NUM_CH-1:0]   ch_onehot;

    always_comb begin
        ch_pick   = wdata[CH_SEL_W-1:0];
        set_bit   = wdata[2];
        ch_onehot = '0;
        ch_onehot[ch_pick] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            req_q  <= '0;
            mask_q <= '1;
            tc_q   <= '0;
        end else if (mclr) begin
            cmd_q  <= '0;
            req_q  <= '0;
            mask_q <= '1;
            tc_q   <= '0;
        end else begin
            if (cmd_we) cmd_q <= wdata;
            if (req_we) req_q <= set_bit ? (req_q | ch_onehot) : (req_q & ~ch_onehot);
            if (mask_one_we)
                mask_q <= set_bit ? (mask_q | ch_onehot) : (mask_q & ~ch_onehot);
            else if (mask_all_we)
                mask_q <= wdata[NUM_CH-1:0];
            else if (mask_none_we)
                mask_q <= '0;
            tc_q <= (stat_rd ? '0 : tc_q) | tc_evt;
        end
    end

    assign command  = cmd_q;
    assign sw_req   = req_q;
    assign mask     = mask_q;
    assign tc_flags = tc_q;

    // R11
    mclr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask == '1 && command == '0 && sw_req == '0 && tc_flags == '0));

    // R6
    tc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclr && tc_evt != '0) |=> ((tc_flags & $past(tc_evt)) == $past(tc_evt)));

    // R6
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && tc_evt == '0) |=> (tc_flags == '0));

    // R9
    mask_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_none_we && !mclr) |=> (mask == '0));

endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
    import dmac_regif_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel,
    input  logic                       rd,
    input  logic                       wr,
    input  logic [3:0]                 addr,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [BYTE_W-1:0]          rdata,
    input  logic [NUM_CH-1:0]          dreq_in,
    input  logic [NUM_CH-1:0]          tc_evt,
    output logic [BYTE_W-1:0]          command_o,
    output logic [NUM_CH-1:0]          mask_o,
    output logic [NUM_CH-1:0]          sw_req_o,
    output logic [NUM_CH*REG_W-1:0]    base_addr_o,
    output logic [NUM_CH*REG_W-1:0]    cur_addr_o,
    output logic [NUM_CH*REG_W-1:0]    base_cnt_o,
    output logic [NUM_CH*REG_W-1:0]    cur_cnt_o,
    output logic [NUM_CH*MODE_W-1:0]   mode_o
);

    logic wr_act, rd_act, chan_loc, chan_acc, hi_sel;
    logic [CH_SEL_W-1:0] loc_ch;
    logic [NUM_CH-1:0]   tc_flags;
    logic [REG_W-1:0]    cur_addr_a [NUM_CH];
    logic [REG_W-1:0]    cur_cnt_a  [NUM_CH];
    logic [REG_W-1:0]    rd_word;

    always_comb begin
        wr_act   = sel && wr;
        rd_act   = sel && rd && !wr;
        chan_loc = !addr[3];
        chan_acc = chan_loc && (wr_act || rd_act);
        loc_ch   = addr[CH_SEL_W:1];
    end

    dmac_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (chan_acc),
        .clear  (wr_act && (addr == LOC_PTR_CLR || addr == LOC_MCLR)),
        .hi_sel (hi_sel)
    );

    dmac_ctrl_regs u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (wr_act && addr == LOC_STAT_CMD),
        .req_we       (wr_act && addr == LOC_REQ),
        .mask_one_we  (wr_act && addr == LOC_MASK_ONE),
        .mask_all_we  (wr_act && addr == LOC_MASK_ALL),
        .mask_none_we (wr_act && addr == LOC_MASK_NONE),
        .mclr         (wr_act && addr == LOC_MCLR),
        .stat_rd      (rd_act && addr == LOC_STAT_CMD),
        .wdata        (wdata),
        .tc_evt       (tc_evt),
        .command      (command_o),
        .sw_req       (sw_req_o),
        .mask         (mask_o),
        .tc_flags     (tc_flags)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic here;
        assign here = wr_act && chan_loc && (loc_ch == CH_SEL_W'(g));

        dmac_chan_regs #(.RW(REG_W), .MW(MODE_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_we   (here && !addr[0]),
            .cnt_we    (here && addr[0]),
            .hi_sel    (hi_sel),
            .wdata     (wdata),
            .mode_we   (wr_act && addr == LOC_MODE && wdata[CH_SEL_W-1:0] == CH_SEL_W'(g)),
            .mode_in   (wdata[BYTE_W-1:BYTE_W-MODE_W]),
            .base_addr (base_addr_o[g*REG_W +: REG_W]),
            .cur_addr  (cur_addr_a[g]),
            .base_cnt  (base_cnt_o[g*REG_W +: REG_W]),
            .cur_cnt   (cur_cnt_a[g]),
            .mode      (mode_o[g*MODE_W +: MODE_W])
        );

        assign cur_addr_o[g*REG_W +: REG_W] = cur_addr_a[g];
        assign cur_cnt_o[g*REG_W +: REG_W]  = cur_cnt_a[g];
    end

    always_comb begin
        rd_word = addr[0] ? cur_cnt_a[loc_ch] : cur_addr_a[loc_ch];
        rdata   = '0;
        if (rd_act) begin
            if (chan_loc) begin
                rdata = hi_sel ? rd_word[15:8] : rd_word[7:0];
            end else if (addr == LOC_STAT_CMD) begin
                rdata = {dreq_in, tc_flags};
            end else if (addr == LOC_MASK_ONE) begin
                rdata = command_o;
            end
        end
    end

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(command_o) && $stable(mask_o) && $stable(sw_req_o) && $stable(mode_o)));

    // R12
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd) |-> (rdata == '0));

    // R7
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && addr == LOC_REQ && wdata[2]) |=> sw_req_o[$past(wdata[1:0])]);

endmodule

// File: tb/dmac_regif_bench.sv
module dmac_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  dreq_in = '0, tc_evt = '0;
    logic [7:0]  command_o;
    logic [3:0]  mask_o, sw_req_o;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
    logic [23:0] mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    dmac_regif u_dmac_regif (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dreq_in(dreq_in), .tc_evt(tc_evt),
        .command_o(command_o), .mask_o(mask_o), .sw_req_o(sw_req_o),
        .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
        .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o), .mode_o(mode_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic pulse_tc(input logic [3:0] v);
        @(negedge clk);
        tc_evt = v;
        @(negedge clk);
        tc_evt = '0;
    endtask

    task automatic t_reset;
        check("R1 mask", mask_o, 4'hF);
        check("R1 command", command_o, 8'h00);
        check("R1 request", sw_req_o, 4'h0);
        bus_rd(4'd8, got);
        check("R1 status", got, 8'h00);
    endtask

    task automatic t_chan;
        bus_wr(4'd12, 8'h00);
        bus_wr(4'd2, 8'h34);
        bus_wr(4'd2, 8'h12);
        check("R2 ch1 base addr", base_addr_o[31:16], 16'h1234);
        check("R2 ch1 cur addr", cur_addr_o[31:16], 16'h1234);
        bus_wr(4'd7, 8'hEF);
        bus_wr(4'd7, 8'hCD);
        check("R2 ch3 base cnt", base_cnt_o[63:48], 16'hCDEF);
        check("R2 ch3 cur cnt", cur_cnt_o[63:48], 16'hCDEF);
        check("R2 ch0 untouched", cur_addr_o[15:0], 16'h0000);
        bus_rd(4'd2, got); check("R4 ch1 addr lo", got, 8'h34);
        bus_rd(4'd2, got); check("R4 ch1 addr hi", got, 8'h12);
        bus_rd(4'd7, got); check("R4 ch3 cnt lo", got, 8'hEF);
        bus_rd(4'd7, got); check("R4 ch3 cnt hi", got, 8'hCD);
    endtask

    task automatic t_ptr_clear;
        bus_wr(4'd0, 8'hAA);
        bus_wr(4'd12, 8'h00);
        bus_wr(4'd0, 8'h55);
        check("R3 pointer clear", base_addr_o[15:0], 16'h0055);
    endtask

    task automatic t_cmd_status;
        bus_wr(4'd8, 8'h5A);
        check("R5 command write", command_o, 8'h5A);
        bus_rd(4'd10, got); check("R5 command read", got, 8'h5A);
        dreq_in = 4'b1001;
        pulse_tc(4'b0100);
        bus_rd(4'd8, got); check("R5 status", got, 8'h94);
        bus_rd(4'd8, got); check("R6 cleared by read", got, 8'h90);
        dreq_in = 4'b0000;
    endtask

    task automatic t_collide;
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = 4'd8; tc_evt = 4'b0001;
        #1 got = rdata;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; tc_evt = '0;
        check("R6 read sees old flags", got, 8'h00);
        bus_rd(4'd8, got); check("R6 same-cycle event kept", got, 8'h01);
        bus_rd(4'd8, got); check("R6 later clear", got, 8'h00);
    endtask

    task automatic t_request;
        bus_wr(4'd9, 8'b0000_0110);
        check("R7 set ch2", sw_req_o, 4'b0100);
        bus_wr(4'd9, 8'b0000_0100);
        check("R7 set ch0", sw_req_o, 4'b0101);
        bus_wr(4'd9, 8'b0000_0010);
        check("R7 clear ch2", sw_req_o, 4'b0001);
    endtask

    task automatic t_mask;
        bus_wr(4'd14, 8'h00);
        check("R9 clear all", mask_o, 4'h0);
        bus_wr(4'd10, 8'b0000_0101);
        check("R8 set ch1", mask_o, 4'b0010);
        bus_wr(4'd15, 8'h0C);
        check("R9 write all", mask_o, 4'b1100);
        bus_wr(4'd10, 8'b0000_0011);
        check("R8 clear ch3", mask_o, 4'b0100);
    endtask

    task automatic t_mode;
        bus_wr(4'd11, 8'hB6);
        check("R10 ch2 mode", mode_o[17:12], 6'h2D);
        check("R10 others", {mode_o[23:18], mode_o[11:0]}, 18'h0);
    endtask

    task automatic t_master_clear;
        bus_wr(4'd8, 8'h77);
        pulse_tc(4'b1000);
        bus_wr(4'd12, 8'h00);
        bus_wr(4'd0, 8'h11);
        bus_wr(4'd13, 8'h00);
        check("R11 mask set", mask_o, 4'hF);
        check("R11 command", command_o, 8'h00);
        check("R11 request", sw_req_o, 4'h0);
        check("R11 mode kept", mode_o[17:12], 6'h2D);
        check("R11 ch1 kept", base_addr_o[31:16], 16'h1234);
        bus_rd(4'd8, got); check("R11 status", got, 8'h00);
        bus_wr(4'd0, 8'h77);
        check("R11 pointer low", base_addr_o[15:0], 16'h0077);
    endtask

    task automatic t_sel_gate;
        bus_wr(4'd12, 8'h00);
        @(negedge clk);
        sel = 1'b0; wr = 1'b1; addr = 4'd8; wdata = 8'hFF;
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; addr = 4'd0;
        @(negedge clk);
        rd = 1'b0;
        check("R12 write without select", command_o, 8'h00);
        bus_rd(4'd9, got); check("R12 unused read", got, 8'h00);
        bus_wr(4'd0, 8'h22);
        check("R12 pointer untouched", base_addr_o[15:0], 16'h0022);
        pulse_tc(4'b1000);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; wr = 1'b1; addr = 4'd8; wdata = 8'h3C;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; wr = 1'b0;
        check("R12 write wins", command_o, 8'h3C);
        bus_rd(4'd8, got); check("R12 flag survives", got, 8'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chan();
        t_ptr_clear();
        t_cmd_status();
        t_collide();
        t_request();
        t_mask();
        t_mode();
        t_master_clear();
        t_sel_gate();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule